// File: doc/BRIEF.md
# Reset and Wake-Up Sequencer

This block decides when a small processor core is held in reset and when its clock runs. A power-on event first waits a programmable power-up delay that is counted on a slow timebase. When a crystal clock source is selected, it then counts oscillator cycles until the clock can be trusted. Only after both steps does the core leave reset. A brown-out flag, the external reset pin and a watchdog timeout are further reset sources. The brown-out flag and the reset pin hold the core in reset while they are asserted. None of the three starts either delay timer.

The block also runs a low-power sleep state, in which the core clock is gated off. The core leaves sleep without a reset when the watchdog expires or when an interrupt request arrives whose individual enable is set. The global interrupt enable is not an input, because it only decides whether a vector is taken after the core wakes. After a wake in crystal mode, the core clock stays gated until the oscillator count completes. A one-hot cause register records the source of the most recent reset or wake, and software can clear it.

Top module: `rstwake_seq`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets `core_rst`=1, `clk_en`=0 and `cause`=6'b000001 (power-on bit).
- R2: After a power-on event with bypass off, `core_rst` stays high until `PWRT_BASE << pwrt_sel` slow-timebase ticks (`slow_tick` pulses) have been counted.
- R3: With `pwrt_bypass`=1, the power-up delay is skipped. The cycle after the power-on pulse ends, the sequencer moves on to the next step.
- R4: In crystal mode (`xtal_mode`=1), `OST_CYCLES` ticks of `osc_tick` are counted after the power-up delay before `core_rst` falls. With `xtal_mode`=0 this count is skipped. `core_rst` falls and `clk_en` rises the cycle after the final tick.
- R5: In run or sleep, a high `bor_evt` or a low `ext_rst_n` raises `core_rst` on the next cycle and holds it. Brown-out wins over the pin. The cause bit is 1 for brown-out and 2 for the pin. Reset is released the cycle after both sources are inactive, and no delay timer runs.
- R6: A watchdog timeout while running gives a full reset of one cycle. The cause bit is 3.
- R7: A `sleep_req` while running gates `clk_en` off on the next cycle, without a reset.
- R8: In sleep, a watchdog timeout (cause bit 4) or an enabled interrupt (cause bit 5) wakes the core with no reset. In crystal mode, `clk_en` returns only after `OST_CYCLES` oscillator ticks.
- R9: An interrupt request whose bit in `irq_en` is 0 does not wake the core and does not change `cause`.
- R10: `cause` holds only the source of the latest reset or wake, one-hot. `cause_clr` zeroes it, and a new event in the same cycle wins over the clear.
- R11: `por_evt` restarts the power-up sequence from any state. The brown-out flag and the reset pin are ignored while the delay or start-up timer is counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low register reset |
| por_evt | input | 1 | Power-on event pulse |
| ext_rst_n | input | 1 | External reset pin, active low |
| bor_evt | input | 1 | Brown-out flag, active high |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| slow_tick | input | 1 | Slow timebase pulse for the power-up delay |
| xtal_mode | input | 1 | Crystal clock source selected |
| pwrt_sel | input | 2 | Power-up delay length select |
| pwrt_bypass | input | 1 | Skip the power-up delay |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| irq_req | input | IRQ_N | Interrupt requests |
| irq_en | input | IRQ_N | Individual interrupt enables |
| sleep_req | input | 1 | Enter sleep request |
| cause_clr | input | 1 | Clear the cause register |
| core_rst | output | 1 | Core held in reset |
| clk_en | output | 1 | Core clock-gate enable |
| cause | output | 6 | One-hot cause of last reset or wake |

## Verification
The checker checks on every cycle that `core_rst` and `clk_en` are never high together and that `cause` never has more than one bit set. It also checks that a power-on pulse, a reset pin pulled low while running, or a watchdog expiry while running all reach `core_rst` on the next cycle. Further checks confirm that a sleeping core with no enabled wake source stays asleep, and that a watchdog wake does not raise reset. The exact lengths of the power-up and start-up delays cannot be expressed as short properties, and neither can the rule that reset sources are ignored while a timer counts. These are shown by the bench's reference model, which tracks every cycle of the power-on, bypass, sleep-wake and clear scenarios.

// File: rtl/rwseq_pkg.sv
// Shared types for the reset and wake-up sequencer.
// Assumes a one-hot cause vector whose bit order is part of the block's interface.
package rwseq_pkg;
    typedef enum logic [2:0] {
        ST_PWRT  = 3'd0,
        ST_OST   = 3'd1,
        ST_HOLD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_SLEEP = 3'd4
    } seq_state_t;

    localparam int CAUSE_W  = 6;
    localparam int CB_POR   = 0;
    localparam int CB_BOR   = 1;
    localparam int CB_EXT   = 2;
    localparam int CB_WDTR  = 3;
    localparam int CB_WDTW  = 4;
    localparam int CB_IRQW  = 5;
endpackage

// File: rtl/rwseq_tick_timer.sv
// Counts tick pulses while run is high and flags the final tick of a window.
// Assumes limit >= 1 and stays stable while the window is counting.
module rwseq_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    // Final tick of the window: this is the limit-th tick counted.
    assign done = run && tick && (cnt == limit - W'(1));

    // Tick counter, zeroed whenever the window is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/rwseq_wake_mask.sv
// Reduces the interrupt requests to a single wake flag through the per-line enables.
// Assumes both vectors are already synchronous to clk.
module rwseq_wake_mask #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic         wake
);
    // Any request line that is individually enabled wakes the core.
    assign wake = |(req & en);
endmodule

// File: rtl/rwseq_cause_reg.sv
// Holds the one-hot cause of the most recent reset or wake.
// Assumes set_vec is zero or one-hot; a set wins over a clear in the same cycle.
module rwseq_cause_reg
    import rwseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr,
    output logic [CAUSE_W-1:0] cause
);
    // Replace on a new event, clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= CAUSE_W'(1) << CB_POR;
        else if (set_vec != '0)
            cause <= set_vec;
        else if (clr)
            cause <= '0;
    end
endmodule

// File: rtl/rstwake_seq.sv
// Reset and wake-up sequencer: orders the power-up delay, the oscillator start-up
// count, held reset sources and the sleep state. It drives core reset and clock gating.
// Assumes every input is synchronous to clk and that the tick inputs are single-cycle pulses.
module rstwake_seq
    import rwseq_pkg::*;
#(
    parameter int IRQ_N      = 4,
    parameter int OST_CYCLES = 1024,
    parameter int PWRT_BASE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_evt,
    input  logic               ext_rst_n,
    input  logic               bor_evt,
    input  logic               osc_tick,
    input  logic               slow_tick,
    input  logic               xtal_mode,
    input  logic [1:0]         pwrt_sel,
    input  logic               pwrt_bypass,
    input  logic               wdt_timeout,
    input  logic [IRQ_N-1:0]   irq_req,
    input  logic [IRQ_N-1:0]   irq_en,
    input  logic               sleep_req,
    input  logic               cause_clr,
    output logic               core_rst,
    output logic               clk_en,
    output logic [CAUSE_W-1:0] cause
);
    localparam int PW_MAX = PWRT_BASE << 3;
    localparam int PW_W   = $clog2(PW_MAX + 1);
    localparam int OST_W  = $clog2(OST_CYCLES + 1);

    seq_state_t         state, nxt;
    logic               ost_wake, nxt_wake;
    logic [CAUSE_W-1:0] set_vec;
    logic               pwrt_done, ost_done, irq_wake, in_sleep;
    logic [PW_W-1:0]    pwrt_limit;

    assign pwrt_limit = PW_W'(PWRT_BASE) << pwrt_sel;
    assign in_sleep   = (state == ST_SLEEP);

    rwseq_tick_timer #(.W(PW_W)) u_pwrt (
        .clk(clk), .rst_n(rst_n), .run(state == ST_PWRT), .restart(por_evt),
        .tick(slow_tick), .limit(pwrt_limit), .done(pwrt_done)
    );

    rwseq_tick_timer #(.W(OST_W)) u_ost (
        .clk(clk), .rst_n(rst_n), .run(state == ST_OST), .restart(por_evt),
        .tick(osc_tick), .limit(OST_W'(OST_CYCLES)), .done(ost_done)
    );

    rwseq_wake_mask #(.N(IRQ_N)) u_wake (
        .req(irq_req), .en(irq_en), .wake(irq_wake)
    );

    rwseq_cause_reg u_cause (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(cause_clr), .cause(cause)
    );

    // Next-state, wake-path and cause selection by source priority.
    always_comb begin
        nxt      = state;
        nxt_wake = ost_wake;
        set_vec  = '0;
        if (por_evt) begin
            nxt      = ST_PWRT;
            nxt_wake = 1'b0;
            set_vec  = CAUSE_W'(1) << CB_POR;
        end else begin
            case (state)
                ST_PWRT: begin
                    if (pwrt_bypass || pwrt_done) begin
                        nxt      = xtal_mode ? ST_OST : ST_RUN;
                        nxt_wake = 1'b0;
                    end
                end
                ST_OST: begin
                    if (ost_done) nxt = ST_RUN;
                end
                ST_HOLD: begin
                    if (!bor_evt && ext_rst_n) nxt = ST_RUN;
                end
                ST_RUN, ST_SLEEP: begin
                    if (bor_evt) begin
                        nxt     = ST_HOLD;
                        set_vec = CAUSE_W'(1) << CB_BOR;
                    end else if (!ext_rst_n) begin
                        nxt     = ST_HOLD;
                        set_vec = CAUSE_W'(1) << CB_EXT;
                    end else if (state == ST_RUN) begin
                        if (wdt_timeout) begin
                            nxt     = ST_HOLD;
                            set_vec = CAUSE_W'(1) << CB_WDTR;
                        end else if (sleep_req) begin
                            nxt = ST_SLEEP;
                        end
                    end else if (wdt_timeout || irq_wake) begin
                        nxt      = xtal_mode ? ST_OST : ST_RUN;
                        nxt_wake = 1'b1;
                        set_vec  = wdt_timeout ? (CAUSE_W'(1) << CB_WDTW)
                                               : (CAUSE_W'(1) << CB_IRQW);
                    end
                end
                default: nxt = ST_PWRT;
            endcase
        end
    end

    // State and wake-path registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PWRT;
            ost_wake <= 1'b0;
        end else begin
            state    <= nxt;
            ost_wake <= nxt_wake;
        end
    end

    // Outputs decoded from state: reset held in delays and holds, clock only in run.
    assign core_rst = (state == ST_PWRT) || (state == ST_HOLD) ||
                      ((state == ST_OST) && !ost_wake);
    assign clk_en   = (state == ST_RUN);
endmodule

// File: rtl/rstwake_seq_chk.sv
// Property checker for the reset and wake-up sequencer, bound into every instance.
// Assumes the bench holds rst_n low across at least one clock edge at start.
module rstwake_seq_chk #(
    parameter int IRQ_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_evt,
    input logic             ext_rst_n,
    input logic             bor_evt,
    input logic             wdt_timeout,
    input logic [IRQ_N-1:0] irq_req,
    input logic [IRQ_N-1:0] irq_en,
    input logic             in_sleep,
    input logic             core_rst,
    input logic             clk_en,
    input logic [5:0]       cause
);
    logic rst_seen;

    // Remembers that the previous edge applied the register reset.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: reset values visible after a reset edge.
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_state: assert (core_rst && !clk_en && cause == 6'b000001);
        end
    end

    a_r7_no_clk_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst && clk_en));

    a_r10_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause));

    a_r11_por_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> (core_rst && !clk_en));

    a_r5_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ext_rst_n) |=> core_rst);

    a_r6_wdt_run_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && wdt_timeout) |=> core_rst);

    a_r9_masked_stays_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && !(|(irq_req & irq_en)) && !wdt_timeout && !por_evt &&
         !bor_evt && ext_rst_n) |=> in_sleep);

    a_r8_wake_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wdt_timeout && !por_evt && !bor_evt && ext_rst_n) |=> !core_rst);
endmodule

bind rstwake_seq rstwake_seq_chk #(.IRQ_N(IRQ_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_rst_n(ext_rst_n),
    .bor_evt(bor_evt), .wdt_timeout(wdt_timeout), .irq_req(irq_req),
    .irq_en(irq_en), .in_sleep(in_sleep), .core_rst(core_rst),
    .clk_en(clk_en), .cause(cause)
);

// File: tb/rstwake_seq_tb.sv
// Bench: a behavioural reference model compared on every clock plus directed scenario checks.
module rstwake_seq_tb;
    localparam int IRQ_N = 4;
    localparam int OSTN  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_evt = 1'b0, ext_rst_n = 1'b1, bor_evt = 1'b0;
    logic osc_tick = 1'b0, slow_tick = 1'b0, xtal_mode = 1'b1, pwrt_bypass = 1'b0;
    logic [1:0] pwrt_sel = 2'd1;
    logic wdt_timeout = 1'b0, sleep_req = 1'b0, cause_clr = 1'b0;
    logic [IRQ_N-1:0] irq_req = '0, irq_en = '0;
    logic core_rst, clk_en;
    logic [5:0] cause;

    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    rstwake_seq #(.IRQ_N(IRQ_N), .OST_CYCLES(OSTN), .PWRT_BASE(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .ext_rst_n(ext_rst_n),
        .bor_evt(bor_evt), .osc_tick(osc_tick), .slow_tick(slow_tick),
        .xtal_mode(xtal_mode), .pwrt_sel(pwrt_sel), .pwrt_bypass(pwrt_bypass),
        .wdt_timeout(wdt_timeout), .irq_req(irq_req), .irq_en(irq_en),
        .sleep_req(sleep_req), .cause_clr(cause_clr), .core_rst(core_rst),
        .clk_en(clk_en), .cause(cause)
    );

    // Reference model: phase names and remaining-tick countdowns.
    typedef enum int {M_DELAY, M_OSC, M_HELD, M_ACTIVE, M_ASLEEP} mphase_t;
    mphase_t m_ph = M_DELAY;
    int  m_left = 0;
    bit  m_wakepath = 0, m_valid = 0;
    int  m_cause = 1;

    task automatic after_delay();
        if (xtal_mode) begin m_ph = M_OSC; m_left = OSTN; end
        else m_ph = M_ACTIVE;
        m_wakepath = 0;
    endtask

    task automatic wake_up(input int c);
        if (xtal_mode) begin m_ph = M_OSC; m_left = OSTN; end
        else m_ph = M_ACTIVE;
        m_wakepath = 1;
        m_cause = c;
    endtask

    always @(posedge clk) begin
        bit fresh;
        fresh = 0;
        cyc++;
        if (!rst_n || por_evt) begin
            m_ph = M_DELAY; m_left = 2 << pwrt_sel; m_cause = 1; m_wakepath = 0;
            fresh = 1; m_valid = 1;
        end else begin
            case (m_ph)
                M_DELAY: if (pwrt_bypass) after_delay();
                         else if (slow_tick) begin
                             m_left--;
                             if (m_left == 0) after_delay();
                         end
                M_OSC: if (osc_tick) begin
                           m_left--;
                           if (m_left == 0) m_ph = M_ACTIVE;
                       end
                M_HELD: if (!bor_evt && ext_rst_n) m_ph = M_ACTIVE;
                default: begin
                    if (bor_evt) begin m_ph = M_HELD; m_cause = 2; fresh = 1; end
                    else if (!ext_rst_n) begin m_ph = M_HELD; m_cause = 4; fresh = 1; end
                    else if (m_ph == M_ACTIVE) begin
                        if (wdt_timeout) begin m_ph = M_HELD; m_cause = 8; fresh = 1; end
                        else if (sleep_req) m_ph = M_ASLEEP;
                    end else if (wdt_timeout) begin wake_up(16); fresh = 1; end
                    else if ((irq_req & irq_en) != 0) begin wake_up(32); fresh = 1; end
                end
            endcase
            if (!fresh && cause_clr) m_cause = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (m_valid) begin
            bit e_rst, e_en;
            e_rst = (m_ph == M_DELAY) || (m_ph == M_HELD) || (m_ph == M_OSC && !m_wakepath);
            e_en  = (m_ph == M_ACTIVE);
            chk(core_rst == e_rst && clk_en == e_en && cause == 6'(m_cause),
                {cur_req, " model"}, {core_rst, clk_en, cause}, {e_rst, e_en, 6'(m_cause)});
        end
    end

    // Tick generators: oscillator every other cycle, slow timebase every eighth.
    always @(negedge clk) begin
        osc_tick  <= (cyc % 2) == 0;
        slow_tick <= (cyc % 8) == 0;
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run(output int n);
        n = 0;
        while (!clk_en && n < 5000) begin step(1); n++; end
    endtask

    initial begin
        int n;
        bit saw_rst;
        step(3);
        cur_req = "R1";
        chk(core_rst == 1 && clk_en == 0, "R1 reset outputs", {core_rst, clk_en}, 2);
        chk(cause == 6'b000001, "R1 reset cause", cause, 1);
        rst_n = 1'b1;

        cur_req = "R2";
        step(20);
        chk(core_rst == 1 && clk_en == 0, "R2 held in delay", core_rst, 1);
        cur_req = "R4";
        wait_run(n);
        chk(n > 2 * OSTN - 40, "R4 start-up count applied", n, 2 * OSTN);

        cur_req = "R3";
        pwrt_bypass = 1'b1; xtal_mode = 1'b0;
        por_evt = 1'b1; step(1); por_evt = 1'b0;
        chk(clk_en == 0, "R3 in delay state", clk_en, 0);
        wait_run(n);
        chk(n == 1, "R3 bypass latency", n, 1);
        chk(cause == 6'b000001, "R10 power-on cause", cause, 1);

        cur_req = "R5";
        ext_rst_n = 1'b0; step(1);
        chk(core_rst == 1, "R5 pin reset", core_rst, 1);
        chk(cause == 6'b000100, "R5 pin cause bit 2", cause, 4);
        step(4); ext_rst_n = 1'b1; step(1);
        chk(core_rst == 0 && clk_en == 1, "R5 immediate release", clk_en, 1);
        bor_evt = 1'b1; ext_rst_n = 1'b0; step(3);
        chk(cause == 6'b000010, "R5 brown-out wins, bit 1", cause, 2);
        bor_evt = 1'b0; ext_rst_n = 1'b1; step(1);

        cur_req = "R6";
        wdt_timeout = 1'b1; step(1); wdt_timeout = 1'b0;
        chk(core_rst == 1 && cause == 6'b001000, "R6 watchdog reset", cause, 8);
        step(1);
        chk(clk_en == 1, "R6 one-cycle reset", clk_en, 1);

        cur_req = "R7";
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        chk(clk_en == 0 && core_rst == 0, "R7 asleep", {clk_en, core_rst}, 0);

        cur_req = "R9";
        irq_req = 4'b0010; irq_en = 4'b0001; step(5);
        chk(clk_en == 0, "R9 masked irq no wake", clk_en, 0);
        chk(cause == 6'b001000, "R9 cause unchanged", cause, 8);

        cur_req = "R8";
        irq_en = 4'b0010; step(1); irq_req = '0;
        chk(clk_en == 1 && core_rst == 0, "R8 irq wake", clk_en, 1);
        chk(cause == 6'b100000, "R8 irq cause bit 5", cause, 32);
        xtal_mode = 1'b1;
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        wdt_timeout = 1'b1; step(1); wdt_timeout = 1'b0;
        chk(cause == 6'b010000, "R8 watchdog wake bit 4", cause, 16);
        saw_rst = 0; n = 0;
        while (!clk_en && n < 5000) begin saw_rst |= core_rst; step(1); n++; end
        chk(!saw_rst, "R8 no reset on wake", saw_rst, 0);
        chk(n > 2 * OSTN - 4, "R8 start-up count after wake", n, 2 * OSTN);

        cur_req = "R10";
        cause_clr = 1'b1; step(1); cause_clr = 1'b0;
        chk(cause == 0, "R10 clear", cause, 0);
        cause_clr = 1'b1; wdt_timeout = 1'b1; step(1);
        cause_clr = 1'b0; wdt_timeout = 1'b0;
        chk(cause == 6'b001000, "R10 event beats clear", cause, 8);
        step(2);

        cur_req = "R11";
        pwrt_bypass = 1'b0; xtal_mode = 1'b0; pwrt_sel = 2'd0;
        por_evt = 1'b1; step(1); por_evt = 1'b0;
        ext_rst_n = 1'b0; bor_evt = 1'b1; step(3); ext_rst_n = 1'b1; bor_evt = 1'b0;
        wait_run(n);
        chk(cause == 6'b000001, "R11 pin ignored in delay", cause, 1);
        chk(clk_en == 1, "R2 delay completes", clk_en, 1);
        pwrt_bypass = 1'b1;
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
        por_evt = 1'b1; irq_req = 4'b0010; step(1); por_evt = 1'b0; irq_req = '0;
        chk(core_rst == 1 && cause == 6'b000001, "R11 power-on beats wake", cause, 1);
        step(4);
        finish_run();
    end
endmodule